// File: doc/BRIEF.md
# System Configuration Register Bank with Per-Register Write Rules

This block holds a small set of 32-bit system configuration words behind a word-wide register bus that spans a 1 KiB address window. Software reads every word back as stored. The write behaviour differs from one word to the next. Some words keep only a masked subset of the written bits. One bit can only be cleared by software. Some lock bits can only be set. An error flag is cleared by writing a one to it. Two protection words accumulate every write by OR.

Only reset can undo a set-only or accumulated bit. Only reset can restore the clear-only bit. A hardware input raises the error flag. The bits only configure other logic and have no effect inside this block.

Any access to an offset that has no register, including an offset that is not word aligned, reads as zero and leaves all state unchanged. Such an access also produces a one-cycle `bad_access` pulse.

Top module: `sysctl_regbank`

## Requirements
- R1: Reset values are: config word 0x7C000001 at offset 0x04, and zero for every other register at offsets 0x00, 0x18, 0x1C, 0x20, 0x24 and 0x28.
- R2: A write to the remap word at offset 0x00 stores the written value ANDed with 0x00000107.
- R3: In the config word at offset 0x04, a write stores the written value ANDed with 0xFCFF0100 in all bits except bit 0.
- R4: Bit 0 of the config word at 0x04 becomes (old bit 0 AND written bit 0), so a write can clear it but never set it again.
- R5: Bits 3:0 of the status/lock word at 0x1C are set-only: each written 1 sets the matching bit, a written 0 leaves it, and only reset clears them.
- R6: Bit 8 of the word at 0x1C is an error flag: writing 1 to bit 8 clears it, and writing 0 to bit 8 leaves it unchanged. Its other bits (31:9, 7:4) always read 0.
- R7: The protection words at 0x20 and 0x28 become (old OR written) on every write, so only reset clears a bit.
- R8: The key word at 0x24 stores only bits 7:0 of a write; bits 31:8 read 0.
- R9: The word at 0x18 is mapped but holds nothing: writes are ignored, it reads 0, and accessing it raises no `bad_access`.
- R10: A read of an unmapped offset returns 0, and a write to one changes no register.
- R11: `bad_access` is high for exactly the one cycle after the clock edge that accepts an access (`req_valid` high) to an unmapped offset, and stays low after mapped accesses.
- R12: Any address whose bits 1:0 are not 00 counts as unmapped, even if it falls inside a register.
- R13: A high `parity_err_set` at a clock edge sets bit 8 of the word at 0x1C. It wins over a write-one-to-clear at the same edge.
- R14: `rd_data` shows the addressed word in the same cycle as a read request. A write takes effect at the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational, 0 when not reading a mapped word |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |
| parity_err_set | input | 1 | Hardware set of the error flag at 0x1C bit 8 |

## Verification
The bench builds the block with `ADDR_W` = 10 and `KEY_W` = 8, the default values. With these values the top word of the 1 KiB window (0x3FC) and the gaps between registers can be addressed as unmapped offsets. The 8-bit key truncation can also be observed at the port. The stimulus drives a hardware flag set on the same edge as a write-one-to-clear. It also drives unaligned offsets that fall inside mapped words, and a mid-run reset that must clear the set-only and accumulated bits.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam int NREG   = 7;

  typedef enum logic [2:0] {
    RULE_MASK,   // plain masked store
    RULE_CLR0,   // masked store, bit 0 clear-only
    RULE_LOCK,   // set-only low bits, W1C flag with hardware set
    RULE_ACC,    // OR-accumulate
    RULE_ZERO    // no storage, reads zero
  } wrule_e;

  localparam logic [DATA_W-1:0] LOCK_BITS = 32'h0000_000F;
  localparam logic [DATA_W-1:0] FLAG_BIT  = 32'h0000_0100;

  function automatic logic [11:0] reg_off(int idx);
    case (idx)
      0: return 12'h000;  // remap
      1: return 12'h004;  // config
      2: return 12'h018;  // sram control (empty)
      3: return 12'h01C;  // lock / flag
      4: return 12'h020;  // protect A
      5: return 12'h024;  // key
      default: return 12'h028; // protect B
    endcase
  endfunction

  function automatic wrule_e reg_rule(int idx);
    case (idx)
      0, 5:    return RULE_MASK;
      1:       return RULE_CLR0;
      2:       return RULE_ZERO;
      3:       return RULE_LOCK;
      default: return RULE_ACC;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(int idx, int key_w);
    case (idx)
      0:       return 32'h0000_0107;
      1:       return 32'hFCFF_0100;
      5:       return (DATA_W'(1) << key_w) - DATA_W'(1);
      default: return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_rst(int idx);
    return (idx == 1) ? 32'h7C00_0001 : '0;
  endfunction

  function automatic logic [DATA_W-1:0] next_word(
      wrule_e rule, logic [DATA_W-1:0] mask, logic [DATA_W-1:0] old,
      logic [DATA_W-1:0] wd, logic we, logic hw);
    logic [DATA_W-1:0] n;
    n = old;
    case (rule)
      RULE_MASK: if (we) n = wd & mask;
      RULE_CLR0: if (we) n = (old & wd & DATA_W'(1)) | (wd & mask);
      RULE_LOCK: begin
        if (we) n = (old | (wd & LOCK_BITS)) & ~(wd & FLAG_BIT);
        if (hw) n = n | FLAG_BIT;
      end
      RULE_ACC:  if (we) n = old | wd;
      default:   n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int ADDR_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic [sysctl_pkg::NREG-1:0] sel,
  output logic                       hit
);
  import sysctl_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_match
    assign sel[i] = req_valid && (req_addr == ADDR_W'(reg_off(i)));
  end
  assign hit = |sel;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R10
  AST_UNALIGNED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |-> !hit); // R12
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg #(
  parameter sysctl_pkg::wrule_e RULE = sysctl_pkg::RULE_MASK,
  parameter logic [31:0] MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] RST  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        hw_set,
  output logic [31:0] q
);
  import sysctl_pkg::*;

  logic [31:0] q_nxt;
  assign q_nxt = next_word(RULE, MASK, q, wdata, we, hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end

  if (RULE == RULE_CLR0) begin : g_a_clr
    AST_CFG_B0_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(q[0])); // R4
  end
  if (RULE == RULE_LOCK) begin : g_a_lock
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(q[3:0]) & ~q[3:0]) == 4'h0)); // R5
    AST_FLAG_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> q[8]); // R13
  end
  if (RULE == RULE_ACC) begin : g_a_acc
    AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(q) & ~q) == 32'h0)); // R7
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int ADDR_W = 10,
  parameter int KEY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              bad_access,
  input  logic              parity_err_set
);
  import sysctl_pkg::*;

  logic [NREG-1:0] sel;
  logic            hit;
  logic [31:0]     word [NREG];
  logic            miss_evt;   // access to an unmapped offset this cycle

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_addr(req_addr), .sel(sel), .hit(hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    sysctl_reg #(
      .RULE(reg_rule(i)),
      .MASK(reg_mask(i, KEY_W)),
      .RST (reg_rst(i))
    ) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(sel[i] && req_write),
      .wdata(req_wdata),
      .hw_set((reg_rule(i) == RULE_LOCK) && parity_err_set),
      .q(word[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i] && !req_write) rd_data = rd_data | word[i];
  end

  assign miss_evt = req_valid && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_access <= 1'b0;
    else        bad_access <= miss_evt;
  end

  AST_MISS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !hit) |-> (rd_data == 32'h0)); // R10
  AST_BAD_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(req_valid)); // R11
  AST_BAD_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> bad_access); // R11
endmodule

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, parity_err_set = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        bad_access;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk; // 200 MHz

  sysctl_regbank #(.ADDR_W(10), .KEY_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .bad_access(bad_access), .parity_err_set(parity_err_set)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        bad;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    // R1 reset values
    '{1'b0, 10'h000, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    '{1'b0, 10'h004, 32'h0, 32'h7C00_0001, 1'b0, 4'd1},
    '{1'b0, 10'h018, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    '{1'b0, 10'h01C, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    '{1'b0, 10'h020, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    '{1'b0, 10'h024, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    '{1'b0, 10'h028, 32'h0, 32'h0000_0000, 1'b0, 4'd1},
    // R2 remap mask
    '{1'b1, 10'h000, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd2},
    '{1'b0, 10'h000, 32'h0, 32'h0000_0107, 1'b0, 4'd2},
    // R3 config mask, R4 bit 0 clear-only
    '{1'b1, 10'h004, 32'hFFFF_FFFE, 32'h0, 1'b0, 4'd3},
    '{1'b0, 10'h004, 32'h0, 32'hFCFF_0100, 1'b0, 4'd3},
    '{1'b1, 10'h004, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd4},
    '{1'b0, 10'h004, 32'h0, 32'hFCFF_0100, 1'b0, 4'd4},
    // R5 set-only locks, R14 read right after write
    '{1'b1, 10'h01C, 32'h0000_0005, 32'h0, 1'b0, 4'd5},
    '{1'b0, 10'h01C, 32'h0, 32'h0000_0005, 1'b0, 4'd14},
    '{1'b1, 10'h01C, 32'h0000_000A, 32'h0, 1'b0, 4'd5},
    '{1'b0, 10'h01C, 32'h0, 32'h0000_000F, 1'b0, 4'd5},
    '{1'b1, 10'h01C, 32'h0000_0000, 32'h0, 1'b0, 4'd5},
    '{1'b0, 10'h01C, 32'h0, 32'h0000_000F, 1'b0, 4'd5},
    // R7 OR accumulation
    '{1'b1, 10'h020, 32'h0000_00F0, 32'h0, 1'b0, 4'd7},
    '{1'b1, 10'h020, 32'h0F00_0000, 32'h0, 1'b0, 4'd7},
    '{1'b1, 10'h020, 32'h0000_0000, 32'h0, 1'b0, 4'd7},
    '{1'b0, 10'h020, 32'h0, 32'h0F00_00F0, 1'b0, 4'd7},
    '{1'b1, 10'h028, 32'h0000_0001, 32'h0, 1'b0, 4'd7},
    '{1'b1, 10'h028, 32'h8000_0000, 32'h0, 1'b0, 4'd7},
    '{1'b0, 10'h028, 32'h0, 32'h8000_0001, 1'b0, 4'd7},
    // R8 key truncation
    '{1'b1, 10'h024, 32'h1234_5678, 32'h0, 1'b0, 4'd8},
    '{1'b0, 10'h024, 32'h0, 32'h0000_0078, 1'b0, 4'd8},
    // R9 empty mapped word
    '{1'b1, 10'h018, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd9},
    '{1'b0, 10'h018, 32'h0, 32'h0000_0000, 1'b0, 4'd9},
    // R10 / R11 unmapped offsets
    '{1'b1, 10'h02C, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd11},
    '{1'b0, 10'h02C, 32'h0, 32'h0000_0000, 1'b1, 4'd10},
    '{1'b0, 10'h028, 32'h0, 32'h8000_0001, 1'b0, 4'd10},
    '{1'b0, 10'h3FC, 32'h0, 32'h0000_0000, 1'b1, 4'd11},
    // R12 unaligned offsets
    '{1'b1, 10'h000, 32'h0000_0000, 32'h0, 1'b0, 4'd12},
    '{1'b1, 10'h001, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd12},
    '{1'b0, 10'h000, 32'h0, 32'h0000_0000, 1'b0, 4'd12},
    '{1'b0, 10'h005, 32'h0, 32'h0000_0000, 1'b1, 4'd12}
  };

  task automatic check(string what, int rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Drive at negedge; read data sampled 1 ns later; bad_access after next posedge.
  task automatic op(logic wr, logic [9:0] a, logic [31:0] d, logic [31:0] exp,
                    logic bad, int rq, logic hw = 1'b0);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    parity_err_set = hw;
    #1;
    if (!wr) check($sformatf("read %h", a), rq, rd_data, exp);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; parity_err_set = 1'b0;
    check($sformatf("bad_access after %h", a), bad ? rq : 11,
          {31'h0, bad_access}, {31'h0, bad});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("bad_access in reset", 1, {31'h0, bad_access}, 32'h0); // R1
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      op(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].exp, VEC[i].bad, int'(VEC[i].rq));

    // idle cycle: pulse must not persist (R11)
    @(negedge clk);
    check("bad_access idle", 11, {31'h0, bad_access}, 32'h0);

    // R13 hardware set of flag; R6 write-one-to-clear semantics
    req_valid = 1'b0; parity_err_set = 1'b1;
    @(negedge clk);
    parity_err_set = 1'b0;
    op(1'b0, 10'h01C, 32'h0, 32'h0000_010F, 1'b0, 13);
    op(1'b1, 10'h01C, 32'h0000_0000, 32'h0, 1'b0, 6);
    op(1'b0, 10'h01C, 32'h0, 32'h0000_010F, 1'b0, 6);
    op(1'b1, 10'h01C, 32'h0000_0100, 32'h0, 1'b0, 6);
    op(1'b0, 10'h01C, 32'h0, 32'h0000_000F, 1'b0, 6);
    op(1'b1, 10'h01C, 32'hFFFF_FEF0, 32'h0, 1'b0, 6);
    op(1'b0, 10'h01C, 32'h0, 32'h0000_000F, 1'b0, 6);
    op(1'b1, 10'h01C, 32'h0000_0100, 32'h0, 1'b0, 13, 1'b1); // same-edge clear and set
    op(1'b0, 10'h01C, 32'h0, 32'h0000_010F, 1'b0, 13);

    // R1 reset restores sticky state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 10'h004, 32'h0, 32'h7C00_0001, 1'b0, 1);
    op(1'b0, 10'h01C, 32'h0, 32'h0000_0000, 1'b0, 1);
    op(1'b0, 10'h020, 32'h0, 32'h0000_0000, 1'b0, 1);
    op(1'b0, 10'h024, 32'h0, 32'h0000_0000, 1'b0, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule